// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns the operand-addressing information of one instruction into the memory address that the access will use. Each cycle it can accept one request. A request carries:

- a mode code;
- the value read from the selected register;
- the program counter;
- the instruction's address or displacement field;
- an access size: byte or word.

One clock later the unit presents the effective address. For the modes that move a pointer, it also presents the updated register value with a write-back enable.

The pointer modes step by the access size: one for a byte, four for a word. Post-increment modes (autoincrement and stack pop) address with the old register value and write back the advanced value. Pre-decrement modes (autodecrement and stack push) first move the pointer downward, then use the moved value both as the address and as the write-back value. The stack therefore grows toward lower addresses. All arithmetic wraps modulo 2^32. The caller decodes the instruction, owns the register file and performs the memory access.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it, out_valid, addr, wb_en, wb_val and illegal are all zero.
- R2: Each output reflects the request presented one clock earlier. out_valid equals the previous cycle's in_valid, and a cycle without a request gives addr, wb_en, wb_val and illegal all zero.
- R3: Mode 0 (register indirect) gives addr = reg_val, and mode 1 (direct) gives addr = field. Neither writes back.
- R4: Mode 2 (base plus displacement) gives addr = reg_val + the low 16 bits of field, zero-extended. The upper field bits are ignored.
- R5: Mode 3 (index) gives addr = field (all 32 bits) + reg_val.
- R6: Mode 4 (PC-relative) gives addr = pc + the low 16 bits of field, sign-extended. This reaches targets both before and after pc.
- R7: Modes 5 (autoincrement) and 8 (stack pop) give addr = reg_val and wb_val = reg_val + step, with wb_en = 1.
- R8: Modes 6 (autodecrement) and 7 (stack push) give addr = wb_val = reg_val - step, with wb_en = 1.
- R9: step is 1 when size_word = 0 and 4 when size_word = 1.
- R10: wb_en is 1 only for a valid request in modes 5 to 8. Whenever wb_en is 0, wb_val is 0.
- R11: Every address and write-back sum wraps modulo 2^32.
- R12: Mode codes 9 to 15 give illegal = 1, addr = 0 and wb_en = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| reg_val | input | 32 | Selected register or stack pointer value |
| pc | input | 32 | Program counter |
| field | input | 32 | Instruction address / displacement field |
| size_word | input | 1 | 0 = byte access, 1 = word access |
| out_valid | output | 1 | Result present |
| addr | output | 32 | Effective address |
| wb_en | output | 1 | Register write-back enable |
| wb_val | output | 32 | Updated register value |
| illegal | output | 1 | Unused mode code seen |

## Verification
The non-pointer modes are tried with field values whose upper half is non-zero and whose bit 15 is set. This separates zero-extension (base mode) from sign-extension (PC-relative mode) and from full-width use (index and direct modes).

Each pointer mode runs with both access sizes. This distinguishes a step of one from a step of four, and exposes whether the address uses the old or the moved register value.

Pointers placed just below 2^32 and at zero show whether sums wrap. Unused codes at both ends of their range, together with idle cycles between requests, show that no stale result or stray write-back leaks out.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int ADDR_W = 32;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_REG_IND = 4'd0,
        MD_DIRECT  = 4'd1,
        MD_BASE    = 4'd2,
        MD_INDEX   = 4'd3,
        MD_PC_REL  = 4'd4,
        MD_AUTOINC = 4'd5,
        MD_AUTODEC = 4'd6,
        MD_PUSH    = 4'd7,
        MD_POP     = 4'd8
    } mode_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              wb_en;
        logic [ADDR_W-1:0] wb_val;
        logic              illegal;
    } ea_result_t;

endpackage

// File: rtl/ea_step_gen.sv
module ea_step_gen #(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          size_word,
    output logic [AW-1:0] step
);
    localparam logic [AW-1:0] BYTE_STEP = AW'(1);
    localparam logic [AW-1:0] WORD_STEP = AW'(WORD_BYTES);

    always_comb begin
        step = size_word ? WORD_STEP : BYTE_STEP;
    end
endmodule

// File: rtl/ea_ptr_adjust.sv
module ea_ptr_adjust #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] ptr_inc,
    output logic [AW-1:0] ptr_dec
);
    always_comb begin
        ptr_inc = ptr + step;
        ptr_dec = ptr - step;
    end
endmodule

// File: rtl/ea_mode_select.sv
module ea_mode_select
    import ea_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 16,
    parameter int REL_W  = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     reg_val,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     field,
    input  logic [AW-1:0]     ptr_inc,
    input  logic [AW-1:0]     ptr_dec,
    output logic [AW-1:0]     ea,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val,
    output logic              illegal
);
    logic [AW-1:0] disp_zx;
    logic [AW-1:0] rel_sx;

    generate
        if (DISP_W < AW) begin : g_disp_narrow
            assign disp_zx = {{(AW-DISP_W){1'b0}}, field[DISP_W-1:0]};
        end else begin : g_disp_full
            assign disp_zx = field;
        end

        if (REL_W < AW) begin : g_rel_narrow
            assign rel_sx = {{(AW-REL_W){field[REL_W-1]}}, field[REL_W-1:0]};
        end else begin : g_rel_full
            assign rel_sx = field;
        end
    endgenerate

    always_comb begin
        ea      = '0;
        wb_en   = 1'b0;
        wb_val  = '0;
        illegal = 1'b0;
        case (mode_e'(mode))
            MD_REG_IND: ea = reg_val;
            MD_DIRECT:  ea = field;
            MD_BASE:    ea = reg_val + disp_zx;
            MD_INDEX:   ea = field + reg_val;
            MD_PC_REL:  ea = pc + rel_sx;
            MD_AUTOINC, MD_POP: begin
                ea     = reg_val;
                wb_en  = 1'b1;
                wb_val = ptr_inc;
            end
            MD_AUTODEC, MD_PUSH: begin
                ea     = ptr_dec;
                wb_en  = 1'b1;
                wb_val = ptr_dec;
            end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import ea_pkg::*;
#(
    parameter int DISP_W     = 16,
    parameter int REL_W      = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [MODE_W-1:0]   mode,
    input  logic [ADDR_W-1:0]   reg_val,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [ADDR_W-1:0]   field,
    input  logic                size_word,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   addr,
    output logic                wb_en,
    output logic [ADDR_W-1:0]   wb_val,
    output logic                illegal
);
    localparam int AW = ADDR_W;

    logic [AW-1:0] step;
    logic [AW-1:0] ptr_inc;
    logic [AW-1:0] ptr_dec;
    logic [AW-1:0] sel_ea;
    logic          sel_wb_en;
    logic [AW-1:0] sel_wb_val;
    logic          sel_illegal;

    ea_result_t res_d;
    ea_result_t res_q;

    ea_step_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_step (
        .size_word (size_word),
        .step      (step)
    );

    ea_ptr_adjust #(.AW(AW)) u_adj (
        .ptr     (reg_val),
        .step    (step),
        .ptr_inc (ptr_inc),
        .ptr_dec (ptr_dec)
    );

    ea_mode_select #(.AW(AW), .DISP_W(DISP_W), .REL_W(REL_W)) u_sel (
        .mode    (mode),
        .reg_val (reg_val),
        .pc      (pc),
        .field   (field),
        .ptr_inc (ptr_inc),
        .ptr_dec (ptr_dec),
        .ea      (sel_ea),
        .wb_en   (sel_wb_en),
        .wb_val  (sel_wb_val),
        .illegal (sel_illegal)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid   = 1'b1;
            res_d.addr    = sel_ea;
            res_d.wb_en   = sel_wb_en;
            res_d.wb_val  = sel_wb_val;
            res_d.illegal = sel_illegal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign addr      = res_q.addr;
    assign wb_en     = res_q.wb_en;
    assign wb_val    = res_q.wb_val;
    assign illegal   = res_q.illegal;
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk
    import ea_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [MODE_W-1:0]   mode,
    input logic [ADDR_W-1:0]   reg_val,
    input logic                size_word,
    input logic                out_valid,
    input logic [ADDR_W-1:0]   addr,
    input logic                wb_en,
    input logic [ADDR_W-1:0]   wb_val,
    input logic                illegal
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en && !illegal && addr == '0));

    // R10
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid);

    // R12
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (addr == '0 && !wb_en));

    // R8
    predec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == MD_AUTODEC || mode == MD_PUSH))
        |=> (wb_en && wb_val == addr));

    // R7
    postinc_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == MD_AUTOINC || mode == MD_POP))
        |=> (wb_en && addr == $past(reg_val)));

    // R9
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MD_AUTOINC && !size_word)
        |=> (wb_val == addr + 32'd1));
endmodule

bind eff_addr_unit eff_addr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .reg_val   (reg_val),
    .size_word (size_word),
    .out_valid (out_valid),
    .addr      (addr),
    .wb_en     (wb_en),
    .wb_val    (wb_val),
    .illegal   (illegal)
);

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb;

    typedef struct {
        logic        v;
        logic [31:0] a;
        logic        we;
        logic [31:0] wv;
        logic        il;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] pc = '0;
    logic [31:0] field = '0;
    logic        size_word = 1'b0;
    logic        out_valid;
    logic [31:0] addr;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    eff_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .reg_val(reg_val), .pc(pc), .field(field), .size_word(size_word),
        .out_valid(out_valid), .addr(addr), .wb_en(wb_en),
        .wb_val(wb_val), .illegal(illegal)
    );

    function automatic exp_t model(input logic v, input logic [3:0] m,
                                   input logic [31:0] r, input logic [31:0] p,
                                   input logic [31:0] f, input logic sz,
                                   input string tag);
        exp_t e;
        logic [31:0] st;
        st = sz ? 32'd4 : 32'd1;
        e.v = v; e.a = '0; e.we = 1'b0; e.wv = '0; e.il = 1'b0; e.tag = tag;
        if (v) begin
            if (m == 4'd0) e.a = r;
            else if (m == 4'd1) e.a = f;
            else if (m == 4'd2) e.a = r + {16'h0, f[15:0]};
            else if (m == 4'd3) e.a = f + r;
            else if (m == 4'd4) e.a = p + {{16{f[15]}}, f[15:0]};
            else if (m == 4'd5 || m == 4'd8) begin
                e.a = r; e.we = 1'b1; e.wv = r + st;
            end else if (m == 4'd6 || m == 4'd7) begin
                e.a = r - st; e.we = 1'b1; e.wv = r - st;
            end else e.il = 1'b1;
        end
        return e;
    endfunction

    task automatic drive(input logic v, input logic [3:0] m, input logic [31:0] r,
                         input logic [31:0] p, input logic [31:0] f,
                         input logic sz, input string tag);
        @(negedge clk);
        in_valid = v; mode = m; reg_val = r; pc = p; field = f; size_word = sz;
        sb.push_back(model(v, m, r, p, f, sz, tag));
    endtask

    // monitor: each pushed item appears one edge later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (out_valid !== e.v || addr !== e.a || wb_en !== e.we ||
                    wb_val !== e.wv || illegal !== e.il) begin
                    bad++;
                    $display("FAIL %s: got v=%0b a=%h we=%0b wv=%h il=%0b exp v=%0b a=%h we=%0b wv=%h il=%0b",
                             e.tag, out_valid, addr, wb_en, wb_val, illegal,
                             e.v, e.a, e.we, e.wv, e.il);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || addr !== '0 || wb_en !== 1'b0 ||
            wb_val !== '0 || illegal !== 1'b0) begin
            bad++;
            $display("FAIL R1: got v=%0b a=%h we=%0b wv=%h il=%0b exp all zero",
                     out_valid, addr, wb_en, wb_val, illegal);
        end
        rst_n = 1'b1;
        drive(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, "R1 first idle");
        drive(1, 4'd0, 32'h0000_1000, 32'h0, 32'hDEAD_BEEF, 0, "R3 reg indirect");
        drive(1, 4'd1, 32'h1234_5678, 32'h0, 32'hABCD_0000, 1, "R3 direct");
        drive(1, 4'd2, 32'h0000_2000, 32'h0, 32'hFFFF_8008, 0, "R4 base zero-ext");
        drive(0, 4'd5, 32'h10, 32'h0, 32'h0, 1, "R2 idle ignores mode");
        drive(1, 4'd3, 32'h0000_0024, 32'h0, 32'h0010_0000, 0, "R5 index");
        drive(1, 4'd4, 32'h0, 32'h0000_0400, 32'h0000_FFF0, 0, "R6 pc-rel backward");
        drive(1, 4'd4, 32'h0, 32'h0000_0400, 32'hFFFF_0020, 0, "R6 pc-rel forward");
        drive(1, 4'd5, 32'h0000_0010, 32'h0, 32'h0, 0, "R7 R9 autoinc byte");
        drive(1, 4'd5, 32'h0000_0010, 32'h0, 32'h0, 1, "R7 R9 autoinc word");
        drive(1, 4'd6, 32'h0000_0010, 32'h0, 32'h0, 1, "R8 autodec word");
        drive(1, 4'd6, 32'h0000_0010, 32'h0, 32'h0, 0, "R8 R9 autodec byte");
        drive(1, 4'd7, 32'h0000_8000, 32'h0, 32'h0, 1, "R8 push word");
        drive(1, 4'd8, 32'h0000_7FFC, 32'h0, 32'h0, 1, "R7 pop word");
        drive(1, 4'd8, 32'h0000_7FFF, 32'h0, 32'h0, 0, "R7 pop byte");
        drive(1, 4'd5, 32'hFFFF_FFFC, 32'h0, 32'h0, 1, "R11 autoinc wrap");
        drive(1, 4'd6, 32'h0000_0000, 32'h0, 32'h0, 0, "R11 autodec wrap");
        drive(1, 4'd4, 32'h0, 32'h0000_0000, 32'h0000_FFFF, 0, "R11 pc-rel wrap");
        drive(1, 4'd2, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020, 0, "R11 base wrap");
        drive(1, 4'd0, 32'h0000_0040, 32'h0, 32'h0, 1, "R10 no wb indirect");
        drive(1, 4'd9, 32'h0000_5555, 32'h1, 32'h2, 1, "R12 illegal 9");
        drive(1, 4'd15, 32'h0000_5555, 32'h1, 32'h2, 0, "R12 illegal 15");
        drive(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, "R2 trailing idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule